// File: doc/BRIEF.md
# Register Rename Map with Branch Snapshots

This block renames architectural registers onto a larger pool of physical registers, one instruction per cycle. A mapping table tells which physical register holds the newest value of each architectural register. A bit vector marks which physical registers are unused. For each instruction the block translates both source operands through the table as it stood before the instruction. If the instruction writes a register, it hands out the lowest-numbered unused physical register and reports the mapping that this write replaces. The surrounding pipeline returns that replaced register at commit.

When a branch is renamed, the block copies the mapping table and the unused-register vector into a free snapshot slot and reports the slot number. A resolution port names a slot. If the branch was predicted correctly, the slot is released and the current state is left alone. If it was mispredicted, both structures are reloaded from the slot in one cycle, and that slot and every slot taken by a younger branch are released. Commits that happen after a snapshot are also written into the snapshot, so a later recovery does not lose registers that were freed in the meantime.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i reads as physical register i, and physical registers NUM_ARCH to NUM_PHYS-1 are unused.
- R2: Both source translations use the mapping in effect before the current instruction's own write, so a source equal to the destination reads the old physical register.
- R3: A renamed write receives the lowest-numbered unused physical register on `ren_pdst` and reports the replaced mapping on `ren_pold`. From the next cycle, the destination reads as the new register.
- R4: `ren_ready` is low while a write is requested and no physical register is unused. An instruction without a destination is still accepted in that state, and a stalled request changes no mapping.
- R5: A renamed branch is given the lowest-numbered unused snapshot slot, reported on `ren_ckpt_id`. A branch is stalled while all slots are occupied.
- R6: A mispredict on slot s reloads the mapping table and the unused-register vector to their values just after that branch was renamed. During the mispredict cycle `ren_ready` is low and no rename takes effect.
- R7: A mispredict on slot s also releases every slot taken after s, while slots taken before s stay occupied.
- R8: A correct resolution on slot s releases that slot and leaves every mapping unchanged.
- R9: A commit of physical register p makes p unused from the next cycle. It also marks p unused in every stored snapshot, so a later mispredict keeps p available.
- R10: With `ren_valid` low, no mapping, unused-register bit or slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Instruction presented for renaming |
| ren_has_dst | input | 1 | Instruction writes an architectural register |
| ren_is_br | input | 1 | Instruction is a branch that needs a snapshot |
| ren_src1 | input | AW | First source architectural register |
| ren_src2 | input | AW | Second source architectural register |
| ren_dst | input | AW | Destination architectural register |
| ren_ready | output | 1 | Instruction is accepted this cycle when valid |
| ren_psrc1 | output | PW | Physical register for the first source |
| ren_psrc2 | output | PW | Physical register for the second source |
| ren_pdst | output | PW | Newly assigned physical register |
| ren_pold | output | PW | Physical register that the destination mapped to before |
| ren_ckpt_id | output | CW | Snapshot slot given to a branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_mispredict | input | 1 | The resolving branch was mispredicted |
| res_ckpt_id | input | CW | Snapshot slot of the resolving branch |
| cmt_valid | input | 1 | A committed instruction releases a register |
| cmt_preg | input | PW | Physical register to release |

## Verification
The hardest state to reach is a mispredict whose snapshot has aged: registers have been assigned after the snapshot, and a register has been committed after it too. Only that state shows whether recovery returns exactly the snapshot's registers plus the committed one. The stimulus drains the pool, commits a few registers, takes a branch and assigns a register behind it. It then commits once more and mispredicts. The expected assignment order after recovery is worked out arithmetically. A second sequence fills every snapshot slot, resolves one in the middle, refills it and mispredicts an older slot, so that the age relation between slots decides which ones come free.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Outcome of a branch resolution as seen by the snapshot controller.
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_OK   = 2'd1,
    RES_BAD  = 2'd2
  } res_kind_t;
endpackage

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int NA = 8,
  parameter int NP = 16,
  parameter int NC = 4,
  localparam int PW = $clog2(NP),
  localparam int CW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          save,
  input  logic [CW-1:0] save_id,
  input  logic          restore,
  input  logic [CW-1:0] restore_id,
  input  logic          ret,
  input  logic [PW-1:0] ret_preg,
  output logic [PW-1:0] pick,
  output logic          empty,
  output logic [NP-1:0] free_vec
);
  logic [NP-1:0] free_q, free_d;
  logic [NP-1:0] ck_q [NC];
  logic [NP-1:0] ck_d [NC];
  logic          free_en, ck_en;

  assign free_vec = free_q;
  assign free_en  = alloc | restore | ret;
  assign ck_en    = save | ret;

  // lowest-numbered unused register
  always_comb begin
    pick = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (free_q[i]) pick = PW'(i);
    end
    empty = ~|free_q;
  end

  always_comb begin
    free_d = free_q;
    if (restore) free_d = ck_q[restore_id];
    else if (alloc) free_d[pick] = 1'b0;
    if (ret) free_d[ret_preg] = 1'b1;
    for (int k = 0; k < NC; k++) begin
      ck_d[k] = ck_q[k];
      if (save && (save_id == CW'(k))) ck_d[k] = free_d;
      if (ret) ck_d[k][ret_preg] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= NA);
    end else if (free_en) begin
      free_q <= free_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) ck_q[k] <= '0;
    end else if (ck_en) begin
      for (int k = 0; k < NC; k++) ck_q[k] <= ck_d[k];
    end
  end
endmodule

// File: rtl/rename_maptable.sv
module rename_maptable #(
  parameter int NA = 8,
  parameter int NP = 16,
  parameter int NC = 4,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP),
  localparam int CW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          write,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_preg,
  input  logic          save,
  input  logic [CW-1:0] save_id,
  input  logic          restore,
  input  logic [CW-1:0] restore_id,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_w,
  output logic [PW-1:0] out_a,
  output logic [PW-1:0] out_b,
  output logic [PW-1:0] out_w
);
  logic [PW-1:0] map_q [NA];
  logic [PW-1:0] map_d [NA];
  logic [PW-1:0] ck_q  [NC][NA];
  logic          map_en;

  assign map_en = write | restore;

  // reads see the table before this cycle's write
  assign out_a = map_q[rd_a];
  assign out_b = map_q[rd_b];
  assign out_w = map_q[rd_w];

  always_comb begin
    for (int a = 0; a < NA; a++) begin
      if (restore) map_d[a] = ck_q[restore_id][a];
      else if (write && (wr_arch == AW'(a))) map_d[a] = wr_preg;
      else map_d[a] = map_q[a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NA; a++) map_q[a] <= PW'(a);
    end else if (map_en) begin
      for (int a = 0; a < NA; a++) map_q[a] <= map_d[a];
    end
  end

  // snapshot holds the table after the branch's own update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++)
        for (int a = 0; a < NA; a++) ck_q[k][a] <= '0;
    end else if (save) begin
      for (int a = 0; a < NA; a++) ck_q[save_id][a] <= map_d[a];
    end
  end
endmodule

// File: rtl/rename_ckpt_ctrl.sv
module rename_ckpt_ctrl
  import rename_pkg::*;
#(
  parameter int NC = 4,
  localparam int CW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  res_kind_t     res_kind,
  input  logic [CW-1:0] res_id,
  output logic          full,
  output logic [CW-1:0] take_id,
  output logic [NC-1:0] slot_valid
);
  logic [NC-1:0] valid_q, valid_d, kill;
  // older_q[k][j] set: slot j was taken before slot k
  logic [NC-1:0] older_q [NC];
  logic [NC-1:0] older_d [NC];
  logic          upd;

  assign slot_valid = valid_q;
  assign upd        = take | (res_kind != RES_NONE);

  always_comb begin
    full    = &valid_q;
    take_id = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (!valid_q[i]) take_id = CW'(i);
    end
  end

  always_comb begin
    kill = '0;
    unique case (res_kind)
      RES_OK:  kill[res_id] = 1'b1;
      RES_BAD: begin
        kill[res_id] = 1'b1;
        for (int k = 0; k < NC; k++) begin
          if (older_q[k][res_id]) kill[k] = 1'b1;
        end
      end
      default: kill = '0;
    endcase
    valid_d = valid_q & ~kill;
    for (int k = 0; k < NC; k++) older_d[k] = older_q[k] & ~kill;
    if (take) begin
      older_d[take_id] = valid_d;
      valid_d[take_id] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int k = 0; k < NC; k++) older_q[k] <= '0;
    end else if (upd) begin
      valid_q <= valid_d;
      for (int k = 0; k < NC; k++) older_q[k] <= older_d[k];
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_CKPT = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_CKPT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_has_dst,
  input  logic          ren_is_br,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_psrc2,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  output logic [CW-1:0] ren_ckpt_id,
  input  logic          res_valid,
  input  logic          res_mispredict,
  input  logic [CW-1:0] res_ckpt_id,
  input  logic          cmt_valid,
  input  logic [PW-1:0] cmt_preg
);
  logic          fire, do_alloc, do_save, do_restore;
  logic          pool_empty, slots_full;
  logic [NUM_PHYS-1:0] free_vec;
  logic [NUM_CKPT-1:0] slot_valid;
  res_kind_t     res_kind;

  assign do_restore = res_valid & res_mispredict;
  assign res_kind   = !res_valid ? RES_NONE : (res_mispredict ? RES_BAD : RES_OK);

  assign ren_ready = ~do_restore
                   & ~(ren_has_dst & pool_empty)
                   & ~(ren_is_br & slots_full);
  assign fire      = ren_valid & ren_ready;
  assign do_alloc  = fire & ren_has_dst;
  assign do_save   = fire & ren_is_br;

  rename_ckpt_ctrl #(.NC(NUM_CKPT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (do_save),
    .res_kind   (res_kind),
    .res_id     (res_ckpt_id),
    .full       (slots_full),
    .take_id    (ren_ckpt_id),
    .slot_valid (slot_valid)
  );

  rename_freelist #(.NA(NUM_ARCH), .NP(NUM_PHYS), .NC(NUM_CKPT)) u_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (do_alloc),
    .save       (do_save),
    .save_id    (ren_ckpt_id),
    .restore    (do_restore),
    .restore_id (res_ckpt_id),
    .ret        (cmt_valid),
    .ret_preg   (cmt_preg),
    .pick       (ren_pdst),
    .empty      (pool_empty),
    .free_vec   (free_vec)
  );

  rename_maptable #(.NA(NUM_ARCH), .NP(NUM_PHYS), .NC(NUM_CKPT)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .write      (do_alloc),
    .wr_arch    (ren_dst),
    .wr_preg    (ren_pdst),
    .save       (do_save),
    .save_id    (ren_ckpt_id),
    .restore    (do_restore),
    .restore_id (res_ckpt_id),
    .rd_a       (ren_src1),
    .rd_b       (ren_src2),
    .rd_w       (ren_dst),
    .out_a      (ren_psrc1),
    .out_b      (ren_psrc2),
    .out_w      (ren_pold)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int NP = 16,
  parameter int NC = 4,
  parameter int PW = 4,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic          ren_has_dst,
  input logic          ren_is_br,
  input logic          ren_ready,
  input logic [PW-1:0] ren_pdst,
  input logic [CW-1:0] ren_ckpt_id,
  input logic          res_valid,
  input logic          res_mispredict,
  input logic [CW-1:0] res_ckpt_id,
  input logic          cmt_valid,
  input logic [PW-1:0] cmt_preg,
  input logic [NP-1:0] free_vec,
  input logic [NC-1:0] slot_valid
);
  // R4: no write accepted with an empty pool
  p_no_alloc_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_has_dst && $countones(free_vec) == 0) |-> !ren_ready);

  // R3: the handed-out register was unused and is in use afterwards
  p_pdst_was_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_has_dst) |-> free_vec[ren_pdst]);
  p_pdst_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_has_dst && !cmt_valid) |=> !free_vec[$past(ren_pdst)]);

  // R5: a branch gets an unused slot, which becomes occupied; no branch while full
  p_slot_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_is_br) |-> !slot_valid[ren_ckpt_id]);
  p_slot_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_is_br) |=> slot_valid[$past(ren_ckpt_id)]);
  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_is_br && (&slot_valid)) |-> !ren_ready);

  // R6: mispredict cycle blocks renaming
  p_bad_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict) |-> !ren_ready);

  // R8: any resolution releases its slot
  p_res_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !slot_valid[$past(res_ckpt_id)]);

  // R9: committed register is unused next cycle
  p_commit_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> free_vec[$past(cmt_preg)]);

  // R10: nothing presented, nothing changes
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_valid && !res_valid && !cmt_valid) |=> ($stable(free_vec) && $stable(slot_valid)));
endmodule

bind rename_unit rename_unit_chk #(
  .NP(NUM_PHYS), .NC(NUM_CKPT), .PW(PW), .CW(CW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ren_valid      (ren_valid),
  .ren_has_dst    (ren_has_dst),
  .ren_is_br      (ren_is_br),
  .ren_ready      (ren_ready),
  .ren_pdst       (ren_pdst),
  .ren_ckpt_id    (ren_ckpt_id),
  .res_valid      (res_valid),
  .res_mispredict (res_mispredict),
  .res_ckpt_id    (res_ckpt_id),
  .cmt_valid      (cmt_valid),
  .cmt_preg       (cmt_preg),
  .free_vec       (free_vec),
  .slot_valid     (slot_valid)
);

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int NC = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_has_dst, ren_is_br;
  logic [2:0] ren_src1, ren_src2, ren_dst;
  logic       ren_ready;
  logic [3:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
  logic [1:0] ren_ckpt_id;
  logic       res_valid, res_mispredict;
  logic [1:0] res_ckpt_id;
  logic       cmt_valid;
  logic [3:0] cmt_preg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_is_br(ren_is_br),
    .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst(ren_dst),
    .ren_ready(ren_ready), .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold), .ren_ckpt_id(ren_ckpt_id),
    .res_valid(res_valid), .res_mispredict(res_mispredict), .res_ckpt_id(res_ckpt_id),
    .cmt_valid(cmt_valid), .cmt_preg(cmt_preg)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    ren_valid = 0; ren_has_dst = 0; ren_is_br = 0;
    ren_src1 = 0; ren_src2 = 0; ren_dst = 0;
    res_valid = 0; res_mispredict = 0; res_ckpt_id = 0;
    cmt_valid = 0; cmt_preg = 0;
  endtask

  // present one instruction for the coming edge; outputs readable after return
  task automatic ren(input bit v, input bit hd, input bit br,
                     input int s1, input int s2, input int d);
    @(negedge clk);
    clear_in();
    ren_valid = v; ren_has_dst = hd; ren_is_br = br;
    ren_src1 = 3'(s1); ren_src2 = 3'(s2); ren_dst = 3'(d);
    #1;
  endtask

  task automatic resolve(input bit mis, input int id, input bit with_write);
    @(negedge clk);
    clear_in();
    res_valid = 1; res_mispredict = mis; res_ckpt_id = 2'(id);
    if (with_write) begin
      ren_valid = 1; ren_has_dst = 1; ren_dst = 3'd2;
    end
    #1;
  endtask

  task automatic commit(input int p);
    @(negedge clk);
    clear_in();
    cmt_valid = 1; cmt_preg = 4'(p);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: identity mapping swept over all architectural registers
    for (int i = 0; i < NA; i++) begin
      ren(0, 0, 0, i, NA - 1 - i, 0);
      check("R1 src1", ren_psrc1, i);
      check("R1 src2", ren_psrc2, NA - 1 - i);
    end
    check("R1 ready", ren_ready, 1);

    // R10: invalid write request leaves the table alone
    ren(0, 1, 0, 3, 0, 3);
    ren(1, 1, 0, 3, 0, 3);
    check("R10 pdst", ren_pdst, NA);
    check("R2 src equals dst", ren_psrc1, 3);
    check("R3 pold", ren_pold, 3);
    ren(0, 0, 0, 3, 0, 0);
    check("R3 new map", ren_psrc1, 8);
    ren(1, 1, 0, 0, 0, 3);
    check("R3 pdst second", ren_pdst, 9);
    check("R3 pold second", ren_pold, 8);

    // R3: drain the pool, registers handed out in ascending order
    for (int k = 0; k < 6; k++) begin
      ren(1, 1, 0, 0, 0, k);
      check("R3 sweep pdst", ren_pdst, 10 + k);
      check("R3 sweep pold", ren_pold, (k == 3) ? 9 : k);
    end

    // R4: empty pool
    ren(1, 1, 0, 0, 0, 6);
    check("R4 stall write", ren_ready, 0);
    ren(1, 0, 0, 0, 0, 0);
    check("R4 no-dst accepted", ren_ready, 1);
    ren(0, 0, 0, 6, 5, 0);
    check("R4 map kept", ren_psrc1, 6);
    check("R4 map kept b", ren_psrc2, 15);

    // R9: commits refill the pool
    commit(3);
    ren(1, 1, 0, 0, 0, 6);
    check("R9 reuse", ren_pdst, 3);
    check("R9 pold", ren_pold, 6);
    commit(8);
    commit(0);

    // R5/R6/R9: snapshot, write behind it, commit, mispredict
    ren(1, 0, 1, 0, 0, 0);
    check("R5 first slot", ren_ckpt_id, 0);
    check("R5 branch ready", ren_ready, 1);
    ren(1, 1, 0, 1, 0, 1);
    check("R6 spec pdst", ren_pdst, 0);
    check("R6 spec pold", ren_pold, 11);
    commit(9);
    resolve(1, 0, 1);
    check("R6 stall in mispredict", ren_ready, 0);
    ren(0, 0, 0, 1, 2, 0);
    check("R6 map restored", ren_psrc1, 11);
    check("R6 no rename in mispredict", ren_psrc2, 12);
    ren(1, 1, 0, 0, 0, 2);
    check("R6 free restored", ren_pdst, 0);
    ren(1, 1, 0, 0, 0, 4);
    check("R6 free order", ren_pdst, 8);
    ren(1, 1, 0, 0, 0, 5);
    check("R9 kept across restore", ren_pdst, 9);
    ren(1, 1, 0, 0, 0, 7);
    check("R6 pool empty again", ren_ready, 0);

    // R5: fill every slot
    for (int b = 0; b < NC; b++) begin
      ren(1, 0, 1, 0, 0, 0);
      check("R5 slot order", ren_ckpt_id, b);
    end
    ren(1, 0, 1, 0, 0, 0);
    check("R5 full stall", ren_ready, 0);

    // R8: correct resolution frees only that slot
    resolve(0, 1, 0);
    ren(0, 0, 0, 2, 4, 0);
    check("R8 map unchanged", ren_psrc1, 0);
    check("R8 map unchanged b", ren_psrc2, 8);
    ren(1, 0, 1, 0, 0, 0);
    check("R8 slot reused", ren_ckpt_id, 1);

    // R7: mispredict slot 2 frees 2, 3 and the refilled 1
    resolve(1, 2, 0);
    for (int b = 1; b < NC; b++) begin
      ren(1, 0, 1, 0, 0, 0);
      check("R7 younger freed", ren_ckpt_id, b);
    end
    ren(1, 0, 1, 0, 0, 0);
    check("R7 older kept", ren_ready, 0);

    // R7: mispredict of the oldest clears all
    resolve(1, 0, 0);
    ren(1, 0, 1, 0, 0, 0);
    check("R7 all freed", ren_ckpt_id, 0);
    ren(0, 0, 0, 5, 7, 0);
    check("R7 map after restore", ren_psrc1, 9);
    check("R7 map after restore b", ren_psrc2, 7);

    @(negedge clk);
    clear_in();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule